// File: doc/BRIEF.md
# Dual Stack Pointer Unit

This block keeps the two stack pointers of a small controller whose stacks share one page of data RAM. The system stack saves 16-bit return addresses. A call or interrupt entry moves it down by two bytes, and a return moves it up by two bytes and restores the saved address. The user stack holds single bytes for push and pop. It grows upward from a top address that software sets, so the two stacks grow towards each other.

The block drives the RAM port directly. It takes the RAM's read data one cycle after the address. It delivers the restored program counter or the popped byte together with a one-cycle completion pulse. Software can read and write the pointers through a configuration-register port. The user pointer can also be read through a read-only input-register port.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset, configuration index 45 reads 0xFF (system pointer), index 6 reads 0x00 (user top), input index 12 reads 0x00 (user pointer), and the page indices 44, 5 and 11 read 32. The busy, done and RAM strobes are low.
- R2: An accepted call writes the high byte of `ret_addr_i` at location SP of page 32 in the accepting cycle. It writes the low byte at SP-1 in the next cycle, with `busy_o` high. SP then reads SP-2.
- R3: An accepted return reads location SP+2 in the accepting cycle and SP+1 in the next cycle, and SP becomes SP+2. In the cycle after that, `ret_done_o` is high for exactly one cycle, with `pc_o` = {byte at SP+2, byte at SP+1}.
- R4: An accepted push writes `push_data_i` at the user pointer location in the same cycle, and the user pointer then increments by one.
- R5: An accepted pop decrements the user pointer and reads the new location. In the next cycle, `pop_done_o` pulses for one cycle with that byte on `pop_data_o`.
- R6: A configuration write to index 6 loads the user top. It also loads the user pointer with the same value.
- R7: A write to index 5 with a value of 32 or more leaves the page reading 32. A value below 32 is ignored. A write to index 44 has no effect on any pointer. Every RAM address the block drives has page byte 32.
- R8: A configuration write to index 45 loads the system pointer.
- R9: At most one operation is accepted per cycle, with priority call, return, push, pop. Strobes seen while `busy_o` is high are ignored.
- R10: Both pointers wrap modulo 256 within page 32.
- R11: Configuration read indices other than 5, 6, 44 and 45, and input read indices other than 11 and 12, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | Call or interrupt entry strobe |
| ret_i | input | 1 | Return strobe |
| push_i | input | 1 | User push strobe |
| pop_i | input | 1 | User pop strobe |
| ret_addr_i | input | 16 | Return address to save on a call |
| push_data_i | input | 8 | Byte to push |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_widx_i | input | 8 | Configuration write index |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_ridx_i | input | 8 | Configuration read index |
| cfg_rdata_o | output | 8 | Configuration read data |
| in_ridx_i | input | 8 | Input-register read index |
| in_rdata_o | output | 8 | Input-register read data |
| ram_addr_o | output | 16 | RAM address {page, location} |
| ram_we_o | output | 1 | RAM write enable |
| ram_re_o | output | 1 | RAM read enable |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data, one cycle after the address |
| busy_o | output | 1 | A multi-cycle operation is in progress |
| ret_done_o | output | 1 | Restored address valid on `pc_o` |
| pc_o | output | 16 | Restored program counter |
| pop_done_o | output | 1 | Popped byte valid on `pop_data_o` |
| pop_data_o | output | 8 | Popped byte |

## Verification
Assertions check on every cycle that the pointers move by the right step, and that at most one pointer move happens per cycle. They also check that the RAM is never read and written at once, that a top write reloads the user pointer, and that the done pulse lasts one cycle. Only the bench scenarios can show the values the RAM delivers: the byte order of a saved return address, the data coming back on return and pop, and the result of priority and of strobes raised while busy. The same applies to wrap-around at the page edge and to the mapping of read indices.

// File: rtl/stkptr_pkg.sv
package stkptr_pkg;
    localparam int DATA_W = 8;
    localparam int LOC_W  = 8;
    localparam int PC_W   = 16;
    localparam int IDX_W  = 8;

    typedef logic [LOC_W-1:0]  loc_t;
    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [IDX_W-1:0]  idx_t;

    localparam idx_t IDX_UTOP_PAGE = idx_t'(5);
    localparam idx_t IDX_UTOP_LOC  = idx_t'(6);
    localparam idx_t IDX_SSP_PAGE  = idx_t'(44);
    localparam idx_t IDX_SSP_LOC   = idx_t'(45);
    localparam idx_t IDX_USP_PAGE  = idx_t'(11);
    localparam idx_t IDX_USP_LOC   = idx_t'(12);

    typedef enum logic [2:0] {
        SEQ_IDLE, SEQ_CALL_LO, SEQ_RET_LO, SEQ_RET_FIN, SEQ_POP_FIN
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_NONE, OP_CALL, OP_RET, OP_PUSH, OP_POP
    } stack_op_e;

    typedef struct packed {
        logic  we;
        logic  re;
        loc_t  loc;
        byte_t wdata;
    } ram_req_t;

    function automatic stack_op_e pick_op(logic c, logic r, logic pu, logic po);
        if (c)  return OP_CALL;
        if (r)  return OP_RET;
        if (pu) return OP_PUSH;
        if (po) return OP_POP;
        return OP_NONE;
    endfunction
endpackage

// File: rtl/sys_stack_ptr.sv
module sys_stack_ptr
    import stkptr_pkg::*;
#(
    parameter loc_t RESET_VAL = loc_t'(8'hFF)
) (
    input  logic clk,
    input  logic rst,
    input  logic dec2_i,
    input  logic inc2_i,
    input  logic wr_i,
    input  loc_t wdata_i,
    output loc_t sp_o
);
    loc_t sp_q;

    always_ff @(posedge clk) begin
        if (rst)         sp_q <= RESET_VAL;
        else if (wr_i)   sp_q <= wdata_i;
        else if (dec2_i) sp_q <= sp_q - loc_t'(2);
        else if (inc2_i) sp_q <= sp_q + loc_t'(2);
    end

    assign sp_o = sp_q;

    assert_sp_down_R2: assert property (@(posedge clk) disable iff (rst)
        (dec2_i && !wr_i) |=> (sp_q == $past(sp_q) - loc_t'(2)));
    assert_sp_up_R3: assert property (@(posedge clk) disable iff (rst)
        (inc2_i && !dec2_i && !wr_i) |=> (sp_q == $past(sp_q) + loc_t'(2)));
    assert_sp_load_R8: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> (sp_q == $past(wdata_i)));
endmodule

// File: rtl/usr_stack_ptr.sv
module usr_stack_ptr
    import stkptr_pkg::*;
#(
    parameter byte_t STACK_PAGE = byte_t'(32),
    parameter loc_t  RESET_VAL  = loc_t'(0)
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  inc_i,
    input  logic  dec_i,
    input  logic  top_wr_i,
    input  logic  page_wr_i,
    input  byte_t wdata_i,
    output loc_t  top_o,
    output byte_t page_o,
    output loc_t  usp_o
);
    loc_t  top_q, usp_q;
    byte_t page_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q  <= RESET_VAL;
            usp_q  <= RESET_VAL;
            page_q <= STACK_PAGE;
        end else begin
            if (page_wr_i && (wdata_i >= STACK_PAGE)) page_q <= STACK_PAGE;
            if (top_wr_i) begin
                top_q <= wdata_i;
                usp_q <= wdata_i;
            end else if (inc_i) begin
                usp_q <= usp_q + loc_t'(1);
            end else if (dec_i) begin
                usp_q <= usp_q - loc_t'(1);
            end
        end
    end

    assign top_o  = top_q;
    assign page_o = page_q;
    assign usp_o  = usp_q;

    assert_top_loads_usp_R6: assert property (@(posedge clk) disable iff (rst)
        top_wr_i |=> (usp_q == $past(wdata_i) && top_q == $past(wdata_i)));
    assert_push_step_R4: assert property (@(posedge clk) disable iff (rst)
        (inc_i && !top_wr_i) |=> (usp_q == $past(usp_q) + loc_t'(1)));
    assert_pop_step_R5: assert property (@(posedge clk) disable iff (rst)
        (dec_i && !inc_i && !top_wr_i) |=> (usp_q == $past(usp_q) - loc_t'(1)));
endmodule

// File: rtl/stack_seq.sv
module stack_seq
    import stkptr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             call_i,
    input  logic             ret_i,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [PC_W-1:0]  ret_addr_i,
    input  byte_t            push_data_i,
    input  loc_t             sp_i,
    input  loc_t             usp_i,
    input  byte_t            ram_rdata_i,
    output ram_req_t         req_o,
    output logic             sys_dec2_o,
    output logic             sys_inc2_o,
    output logic             usr_inc_o,
    output logic             usr_dec_o,
    output logic             busy_o,
    output logic             ret_done_o,
    output logic [PC_W-1:0]  pc_o,
    output logic             pop_done_o,
    output byte_t            pop_data_o
);
    seq_state_e state_q, state_d;
    stack_op_e  op;
    byte_t      lo_q, hi_q;

    assign op = (state_q == SEQ_IDLE) ? pick_op(call_i, ret_i, push_i, pop_i) : OP_NONE;

    always_comb begin
        req_o   = '0;
        state_d = state_q;
        case (state_q)
            SEQ_IDLE: begin
                case (op)
                    OP_CALL: begin
                        req_o.we    = 1'b1;
                        req_o.loc   = sp_i;
                        req_o.wdata = ret_addr_i[PC_W-1:DATA_W];
                        state_d     = SEQ_CALL_LO;
                    end
                    OP_RET: begin
                        req_o.re  = 1'b1;
                        req_o.loc = sp_i + loc_t'(2);
                        state_d   = SEQ_RET_LO;
                    end
                    OP_PUSH: begin
                        req_o.we    = 1'b1;
                        req_o.loc   = usp_i;
                        req_o.wdata = push_data_i;
                    end
                    OP_POP: begin
                        req_o.re  = 1'b1;
                        req_o.loc = usp_i - loc_t'(1);
                        state_d   = SEQ_POP_FIN;
                    end
                    default: ;
                endcase
            end
            SEQ_CALL_LO: begin
                req_o.we    = 1'b1;
                req_o.loc   = sp_i + loc_t'(1);
                req_o.wdata = lo_q;
                state_d     = SEQ_IDLE;
            end
            SEQ_RET_LO: begin
                req_o.re  = 1'b1;
                req_o.loc = sp_i - loc_t'(1);
                state_d   = SEQ_RET_FIN;
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            lo_q    <= '0;
            hi_q    <= '0;
        end else begin
            state_q <= state_d;
            if (op == OP_CALL)          lo_q <= ret_addr_i[DATA_W-1:0];
            if (state_q == SEQ_RET_LO)  hi_q <= ram_rdata_i;
        end
    end

    assign sys_dec2_o = (op == OP_CALL);
    assign sys_inc2_o = (op == OP_RET);
    assign usr_inc_o  = (op == OP_PUSH);
    assign usr_dec_o  = (op == OP_POP);
    assign busy_o     = (state_q != SEQ_IDLE);
    assign ret_done_o = (state_q == SEQ_RET_FIN);
    assign pc_o       = {hi_q, ram_rdata_i};
    assign pop_done_o = (state_q == SEQ_POP_FIN);
    assign pop_data_o = ram_rdata_i;

    assert_one_move_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sys_dec2_o, sys_inc2_o, usr_inc_o, usr_dec_o}));
    assert_port_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        !(req_o.we && req_o.re));
    assert_call_second_write_R2: assert property (@(posedge clk) disable iff (rst)
        sys_dec2_o |=> (req_o.we && busy_o && req_o.wdata == $past(ret_addr_i[DATA_W-1:0])));
    assert_ret_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        ret_done_o |=> !ret_done_o);
    assert_pop_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        usr_dec_o |=> (pop_done_o && busy_o));
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
    import stkptr_pkg::*;
#(
    parameter logic [7:0] STACK_PAGE = 8'd32,
    parameter logic [7:0] SYS_RESET  = 8'hFF,
    parameter logic [7:0] USR_RESET  = 8'h00
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        call_i,
    input  logic        ret_i,
    input  logic        push_i,
    input  logic        pop_i,
    input  logic [15:0] ret_addr_i,
    input  logic [7:0]  push_data_i,
    input  logic        cfg_we_i,
    input  logic [7:0]  cfg_widx_i,
    input  logic [7:0]  cfg_wdata_i,
    input  logic [7:0]  cfg_ridx_i,
    output logic [7:0]  cfg_rdata_o,
    input  logic [7:0]  in_ridx_i,
    output logic [7:0]  in_rdata_o,
    output logic [15:0] ram_addr_o,
    output logic        ram_we_o,
    output logic        ram_re_o,
    output logic [7:0]  ram_wdata_o,
    input  logic [7:0]  ram_rdata_i,
    output logic        busy_o,
    output logic        ret_done_o,
    output logic [15:0] pc_o,
    output logic        pop_done_o,
    output logic [7:0]  pop_data_o
);
    loc_t     sp, usp, utop;
    byte_t    upage;
    ram_req_t req;
    logic     sys_dec2, sys_inc2, usr_inc, usr_dec;
    logic     ssp_wr, utop_wr, upage_wr;

    assign ssp_wr   = cfg_we_i && (cfg_widx_i == IDX_SSP_LOC);
    assign utop_wr  = cfg_we_i && (cfg_widx_i == IDX_UTOP_LOC);
    assign upage_wr = cfg_we_i && (cfg_widx_i == IDX_UTOP_PAGE);

    stack_seq u_seq (
        .clk(clk), .rst(rst),
        .call_i(call_i), .ret_i(ret_i), .push_i(push_i), .pop_i(pop_i),
        .ret_addr_i(ret_addr_i), .push_data_i(push_data_i),
        .sp_i(sp), .usp_i(usp), .ram_rdata_i(ram_rdata_i),
        .req_o(req),
        .sys_dec2_o(sys_dec2), .sys_inc2_o(sys_inc2),
        .usr_inc_o(usr_inc), .usr_dec_o(usr_dec),
        .busy_o(busy_o), .ret_done_o(ret_done_o), .pc_o(pc_o),
        .pop_done_o(pop_done_o), .pop_data_o(pop_data_o)
    );

    sys_stack_ptr #(.RESET_VAL(SYS_RESET)) u_sys (
        .clk(clk), .rst(rst),
        .dec2_i(sys_dec2), .inc2_i(sys_inc2),
        .wr_i(ssp_wr), .wdata_i(cfg_wdata_i),
        .sp_o(sp)
    );

    usr_stack_ptr #(.STACK_PAGE(STACK_PAGE), .RESET_VAL(USR_RESET)) u_usr (
        .clk(clk), .rst(rst),
        .inc_i(usr_inc), .dec_i(usr_dec),
        .top_wr_i(utop_wr), .page_wr_i(upage_wr), .wdata_i(cfg_wdata_i),
        .top_o(utop), .page_o(upage), .usp_o(usp)
    );

    assign ram_addr_o  = {STACK_PAGE, req.loc};
    assign ram_we_o    = req.we;
    assign ram_re_o    = req.re;
    assign ram_wdata_o = req.wdata;

    always_comb begin
        case (cfg_ridx_i)
            IDX_UTOP_PAGE: cfg_rdata_o = upage;
            IDX_UTOP_LOC:  cfg_rdata_o = utop;
            IDX_SSP_PAGE:  cfg_rdata_o = STACK_PAGE;
            IDX_SSP_LOC:   cfg_rdata_o = sp;
            default:       cfg_rdata_o = '0;
        endcase
        case (in_ridx_i)
            IDX_USP_PAGE: in_rdata_o = STACK_PAGE;
            IDX_USP_LOC:  in_rdata_o = usp;
            default:      in_rdata_o = '0;
        endcase
    end

    assert_page_fixed_R7: assert property (@(posedge clk) disable iff (rst)
        (ram_we_o || ram_re_o) |-> (ram_addr_o[15:8] == STACK_PAGE && upage == STACK_PAGE));
    assert_ssp_page_write_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_we_i && cfg_widx_i == IDX_SSP_PAGE && !sys_dec2 && !sys_inc2) |=> $stable(sp));
endmodule

// File: tb/tb_stack_ptr_unit.sv
module tb_stack_ptr_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        call_i = 0, ret_i = 0, push_i = 0, pop_i = 0;
    logic [15:0] ret_addr_i = '0;
    logic [7:0]  push_data_i = '0;
    logic        cfg_we_i = 0;
    logic [7:0]  cfg_widx_i = '0, cfg_wdata_i = '0, cfg_ridx_i = '0, in_ridx_i = '0;
    logic [7:0]  cfg_rdata_o, in_rdata_o, ram_wdata_o, pop_data_o;
    logic [7:0]  ram_rdata_i = '0;
    logic [15:0] ram_addr_o, pc_o;
    logic        ram_we_o, ram_re_o, busy_o, ret_done_o, pop_done_o;

    int   checks = 0, fails = 0;
    bit   finished = 0;
    logic [7:0] m_sp, m_usp;
    logic [7:0] mem [256];

    always #5 clk = ~clk;

    stack_ptr_unit dut (
        .clk(clk), .rst(rst),
        .call_i(call_i), .ret_i(ret_i), .push_i(push_i), .pop_i(pop_i),
        .ret_addr_i(ret_addr_i), .push_data_i(push_data_i),
        .cfg_we_i(cfg_we_i), .cfg_widx_i(cfg_widx_i), .cfg_wdata_i(cfg_wdata_i),
        .cfg_ridx_i(cfg_ridx_i), .cfg_rdata_o(cfg_rdata_o),
        .in_ridx_i(in_ridx_i), .in_rdata_o(in_rdata_o),
        .ram_addr_o(ram_addr_o), .ram_we_o(ram_we_o), .ram_re_o(ram_re_o),
        .ram_wdata_o(ram_wdata_o), .ram_rdata_i(ram_rdata_i),
        .busy_o(busy_o), .ret_done_o(ret_done_o), .pc_o(pc_o),
        .pop_done_o(pop_done_o), .pop_data_o(pop_data_o)
    );

    // one-cycle-latency RAM model covering the stack page
    always @(posedge clk) begin
        if (ram_we_o) mem[ram_addr_o[7:0]] <= ram_wdata_o;
        ram_rdata_i <= mem[ram_addr_o[7:0]];
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd_cfg(input logic [7:0] idx, output logic [7:0] v);
        cfg_ridx_i = idx; #1; v = cfg_rdata_o;
    endtask

    task automatic rd_in(input logic [7:0] idx, output logic [7:0] v);
        in_ridx_i = idx; #1; v = in_rdata_o;
    endtask

    task automatic cfg_write(input logic [7:0] idx, input logic [7:0] val);
        @(negedge clk); cfg_we_i = 1; cfg_widx_i = idx; cfg_wdata_i = val;
        @(negedge clk); cfg_we_i = 0;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd_cfg(8'd45, v); chk("R1 sp", v, 8'hFF);
        rd_cfg(8'd44, v); chk("R1 sp page", v, 32);
        rd_cfg(8'd5, v);  chk("R1 top page", v, 32);
        rd_cfg(8'd6, v);  chk("R1 top", v, 0);
        rd_in(8'd11, v);  chk("R1 usp page", v, 32);
        rd_in(8'd12, v);  chk("R1 usp", v, 0);
        chk("R1 idle", {busy_o, ret_done_o, pop_done_o, ram_we_o, ram_re_o}, 0);
        m_sp = 8'hFF; m_usp = 8'h00;
    endtask

    task automatic t_call(input logic [15:0] pc);
        logic [7:0] s, v;
        s = m_sp;
        @(negedge clk); ret_addr_i = pc; call_i = 1; #1;
        chk("R2 hi write", {ram_we_o, ram_addr_o, ram_wdata_o}, {1'b1, 8'd32, s, pc[15:8]});
        @(negedge clk); call_i = 0; #1;
        chk("R2 lo write", {busy_o, ram_we_o, ram_addr_o, ram_wdata_o},
            {2'b11, 8'd32, 8'(s - 8'd1), pc[7:0]});
        @(negedge clk);
        m_sp = s - 8'd2;
        rd_cfg(8'd45, v); chk("R2 sp", v, m_sp);
        chk("R2 busy clear", busy_o, 0);
    endtask

    task automatic t_ret(input logic [15:0] exp_pc);
        logic [7:0] s, v;
        s = m_sp + 8'd2;
        @(negedge clk); ret_i = 1; #1;
        chk("R3 hi read", {ram_re_o, ram_we_o, ram_addr_o}, {2'b10, 8'd32, s});
        @(negedge clk); ret_i = 0; #1;
        chk("R3 lo read", {ram_re_o, ram_addr_o, ret_done_o}, {1'b1, 8'd32, 8'(s - 8'd1), 1'b0});
        @(negedge clk); #1;
        chk("R3 done", ret_done_o, 1);
        chk("R3 pc", pc_o, exp_pc);
        @(negedge clk); #1;
        chk("R3 done pulse", ret_done_o, 0);
        m_sp = s;
        rd_cfg(8'd45, v); chk("R3 sp", v, m_sp);
    endtask

    task automatic t_push(input logic [7:0] d);
        logic [7:0] v;
        @(negedge clk); push_data_i = d; push_i = 1; #1;
        chk("R4 write", {ram_we_o, ram_addr_o, ram_wdata_o}, {1'b1, 8'd32, m_usp, d});
        @(negedge clk); push_i = 0;
        m_usp = m_usp + 8'd1;
        rd_in(8'd12, v); chk("R4 usp", v, m_usp);
    endtask

    task automatic t_pop(input logic [7:0] exp_d);
        logic [7:0] v;
        @(negedge clk); pop_i = 1; #1;
        chk("R5 read", {ram_re_o, ram_addr_o}, {1'b1, 8'd32, 8'(m_usp - 8'd1)});
        @(negedge clk); pop_i = 0; #1;
        chk("R5 done", {pop_done_o, pop_data_o}, {1'b1, exp_d});
        m_usp = m_usp - 8'd1;
        rd_in(8'd12, v); chk("R5 usp", v, m_usp);
        @(negedge clk); #1;
        chk("R5 done pulse", pop_done_o, 0);
    endtask

    task automatic t_top_write;
        logic [7:0] v;
        cfg_write(8'd6, 8'h40);
        rd_cfg(8'd6, v); chk("R6 top", v, 8'h40);
        rd_in(8'd12, v); chk("R6 usp follows top", v, 8'h40);
        m_usp = 8'h40;
    endtask

    task automatic t_page_clamp;
        logic [7:0] v;
        cfg_write(8'd5, 8'h10);
        rd_cfg(8'd5, v); chk("R7 low page ignored", v, 32);
        cfg_write(8'd5, 8'hC8);
        rd_cfg(8'd5, v); chk("R7 high page clamps", v, 32);
        cfg_write(8'd44, 8'h55);
        rd_cfg(8'd44, v); chk("R7 sp page fixed", v, 32);
        rd_cfg(8'd45, v); chk("R7 sp untouched", v, m_sp);
        rd_in(8'd12, v);  chk("R7 usp untouched", v, m_usp);
    endtask

    task automatic t_sp_write;
        logic [7:0] v;
        cfg_write(8'd45, 8'h80);
        rd_cfg(8'd45, v); chk("R8 sp load", v, 8'h80);
        m_sp = 8'h80;
        t_call(16'hBEEF);
        t_ret(16'hBEEF);
    endtask

    task automatic t_priority;
        logic [7:0] v;
        logic [7:0] s;
        s = m_sp;
        // all four strobes: call wins
        @(negedge clk); ret_addr_i = 16'h1357; push_data_i = 8'hEE;
        call_i = 1; ret_i = 1; push_i = 1; pop_i = 1; #1;
        chk("R9 call wins", {ram_we_o, ram_addr_o, ram_wdata_o}, {1'b1, 8'd32, s, 8'h13});
        // strobes held while busy must be ignored
        @(negedge clk); call_i = 0; ret_i = 0; pop_i = 0; push_i = 1; #1;
        chk("R9 busy ignores push", {ram_we_o, ram_addr_o, ram_wdata_o},
            {1'b1, 8'd32, 8'(s - 8'd1), 8'h57});
        @(negedge clk); push_i = 0;
        m_sp = s - 8'd2;
        rd_in(8'd12, v);  chk("R9 usp unchanged", v, m_usp);
        rd_cfg(8'd45, v); chk("R9 sp after call", v, m_sp);
        // return beats push and pop
        @(negedge clk); ret_i = 1; push_i = 1; pop_i = 1; #1;
        chk("R9 ret wins", {ram_re_o, ram_we_o, ram_addr_o}, {2'b10, 8'd32, s});
        @(negedge clk); ret_i = 0; push_i = 0; pop_i = 0;
        @(negedge clk); #1;
        chk("R9 ret result", {ret_done_o, pc_o}, {1'b1, 16'h1357});
        @(negedge clk);
        m_sp = s;
        rd_in(8'd12, v); chk("R9 usp after ret", v, m_usp);
        // push beats pop
        @(negedge clk); push_data_i = 8'h6C; push_i = 1; pop_i = 1; #1;
        chk("R9 push wins", {ram_we_o, ram_re_o, ram_addr_o}, {2'b10, 8'd32, m_usp});
        @(negedge clk); push_i = 0; pop_i = 0;
        m_usp = m_usp + 8'd1;
        rd_in(8'd12, v); chk("R9 usp after push", v, m_usp);
        t_pop(8'h6C);
    endtask

    task automatic t_wrap;
        logic [7:0] v;
        cfg_write(8'd45, 8'h01);
        m_sp = 8'h01;
        t_call(16'hC3A5);
        rd_cfg(8'd45, v); chk("R10 sp wraps down", v, 8'hFF);
        t_ret(16'hC3A5);
        rd_cfg(8'd45, v); chk("R10 sp wraps up", v, 8'h01);
        cfg_write(8'd6, 8'hFF);
        m_usp = 8'hFF;
        t_push(8'h77);
        rd_in(8'd12, v); chk("R10 usp wraps up", v, 8'h00);
        t_pop(8'h77);
        rd_in(8'd12, v); chk("R10 usp wraps down", v, 8'hFF);
    endtask

    task automatic t_readmap;
        logic [7:0] v;
        rd_cfg(8'd7, v);  chk("R11 cfg other", v, 0);
        rd_cfg(8'd46, v); chk("R11 cfg other", v, 0);
        rd_in(8'd13, v);  chk("R11 input other", v, 0);
        rd_in(8'd0, v);   chk("R11 input other", v, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_readmap();
        t_call(16'hABCD);
        t_call(16'h1234);
        t_ret(16'h1234);
        t_ret(16'hABCD);
        t_top_write();
        t_push(8'h11);
        t_push(8'h22);
        t_push(8'h33);
        t_pop(8'h33);
        t_pop(8'h22);
        t_page_clamp();
        t_sp_write();
        t_priority();
        t_wrap();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule